// File: doc/BRIEF.md
# Serial Port Personality and Transfer-Start Controller

This block sits in front of a shared serial port that can take on one of seven personalities: UART, SPI master or slave, I2C master or slave, and serial or parallel LCD output. A 3-bit mode register picks the personality, and code zero holds every protocol engine in soft reset. The same one-byte transmit and receive buffers serve every personality. The personality decides what lets a buffered transmit byte leave for the engine. In the write-driven modes the byte leaves as soon as the engine is ready. In SPI slave mode it waits for the remote master's shift clock. In the I2C modes it waits for a separate software trigger.

The engines themselves are outside the block. Each one sees a single-cycle start strobe on its own lane of a one-hot bus, along with the byte to load. It returns a ready level, and a done pulse with the received byte. Software sees a transmit-empty flag and a receive-full flag, plus sticky overrun bits for both directions.

Top module: `sio_mode_ctrl`

## Requirements
- R1: After reset, the mode is 0 and soft reset is asserted. Start strobes, the transmit-empty flag, the receive-full flag, both overrun bits and the configuration register are all 0.
- R2: Mode codes are 1 UART, 2 SPI master, 3 SPI slave, 4 I2C master, 5 I2C slave, 6 LCD serial and 7 LCD parallel. A transfer start pulses only the bit of `start_o` whose index equals the current mode code. `soft_rst_o` is 1 exactly when the mode is 0.
- R3: A mode write of 0 is always taken. A mode write of a nonzero code is taken only while the mode is 0, so changing personality needs a pass through 0.
- R4: A configuration write updates `cfg_o` only while the mode is nonzero. In mode 0 it is ignored.
- R5: In modes 1, 2, 6 and 7, a buffered byte starts in the first cycle after its write in which `eng_ready_i` is 1. No start is issued while `eng_ready_i` is 0.
- R6: In mode 3, a buffered byte starts only in a cycle where both `ext_clk_act_i` and `eng_ready_i` are 1.
- R7: In modes 4 and 5, a buffer write alone never starts a transfer. A `sw_trig_i` pulse arms a pending trigger, and the byte starts in a later cycle where the trigger is armed, the buffer is full and the engine is ready. The order of trigger and write does not matter.
- R8: `txe_o` rises in the cycle after a start and is cleared by a transmit write. If a write lands in the same cycle as a start, the old byte goes out, the new byte stays pending and `txe_o` stays 0.
- R9: A transmit write while a byte is still pending and not starting in that cycle replaces the byte and sets the sticky `tx_ovr_o`.
- R10: An `rx_done_i` pulse loads `rx_data_i` into `rd_data_o` and sets `rxf_o`. A `rd_re_i` pulse clears `rxf_o`, and `rd_data_o` holds the byte until the next load.
- R11: An `rx_done_i` pulse while `rxf_o` is set and no read happens in that cycle replaces the byte and sets the sticky `rx_ovr_o`.
- R12: While the mode is 0, the pending bytes, both flags, both overrun bits and the armed trigger are cleared. Transmit writes and receive loads are ignored, so no start follows when a personality is selected afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 3 | Mode code to write |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | CFG_W | Configuration value |
| tx_we_i | input | 1 | Transmit buffer write strobe |
| tx_wdata_i | input | DATA_W | Transmit byte |
| sw_trig_i | input | 1 | Software send trigger for the I2C modes |
| ext_clk_act_i | input | 1 | Remote master is driving the shift clock |
| eng_ready_i | input | 1 | Engine can accept a byte |
| rx_done_i | input | 1 | Engine has received a byte |
| rx_data_i | input | DATA_W | Received byte |
| rd_re_i | input | 1 | Receive buffer read strobe |
| mode_o | output | 3 | Current mode code |
| cfg_o | output | CFG_W | Accepted configuration |
| soft_rst_o | output | 1 | Soft reset to the engines |
| start_o | output | 8 | One-hot start strobe, indexed by mode code |
| tx_data_o | output | DATA_W | Byte handed to the engine on start |
| txe_o | output | 1 | Transmit buffer empty flag |
| tx_ovr_o | output | 1 | Sticky transmit overrun |
| rd_data_o | output | DATA_W | Receive buffer contents |
| rxf_o | output | 1 | Receive buffer full flag |
| rx_ovr_o | output | 1 | Sticky receive overrun |

## Verification
The two functions that can fall in the same cycle are the hand-off of the pending byte to the engine and a new transmit write. The bench provokes this by holding the engine not-ready with a byte pending, then raising ready and writing the next byte on the same edge. It then judges that both bytes come out in order on the scoreboard, that `txe_o` stays low after that edge, and that `tx_ovr_o` stays clear. Any start that is unexpected, out of order, on the wrong lane, or missing at the end is reported by the scoreboard.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int MODE_W    = 3;
  localparam int NUM_MODES = 1 << MODE_W;

  typedef enum logic [MODE_W-1:0] {
    MD_RESET   = 3'd0,
    MD_UART    = 3'd1,
    MD_SPI_M   = 3'd2,
    MD_SPI_S   = 3'd3,
    MD_I2C_M   = 3'd4,
    MD_I2C_S   = 3'd5,
    MD_LCD_SER = 3'd6,
    MD_LCD_PAR = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    ST_NEVER,
    ST_ON_WRITE,
    ST_ON_EXT_CLK,
    ST_ON_TRIG
  } start_pol_e;

  function automatic start_pol_e pol_of(mode_e m);
    case (m)
      MD_UART, MD_SPI_M, MD_LCD_SER, MD_LCD_PAR: pol_of = ST_ON_WRITE;
      MD_SPI_S:                                  pol_of = ST_ON_EXT_CLK;
      MD_I2C_M, MD_I2C_S:                        pol_of = ST_ON_TRIG;
      default:                                   pol_of = ST_NEVER;
    endcase
  endfunction
endpackage

// File: rtl/sio_mode_reg.sv
module sio_mode_reg
  import sio_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_we_i,
  input  logic [MODE_W-1:0]   mode_wdata_i,
  input  logic                cfg_we_i,
  input  logic [CFG_W-1:0]    cfg_wdata_i,
  output mode_e               mode_o,
  output logic [CFG_W-1:0]    cfg_o,
  output logic                soft_rst_o
);
  mode_e            mode_q;
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MD_RESET;
    end else if (mode_we_i) begin
      // leaving a personality is always allowed, entering one only from reset
      if (mode_wdata_i == '0)         mode_q <= MD_RESET;
      else if (mode_q == MD_RESET)    mode_q <= mode_e'(mode_wdata_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cfg_q <= '0;
    else if (cfg_we_i && mode_q != MD_RESET) cfg_q <= cfg_wdata_i;
  end

  assign mode_o     = mode_q;
  assign cfg_o      = cfg_q;
  assign soft_rst_o = (mode_q == MD_RESET);
endmodule

// File: rtl/sio_tx_buf.sv
module sio_tx_buf
  import sio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  mode_e                mode_i,
  input  logic                 soft_rst_i,
  input  logic                 we_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 trig_i,
  input  logic                 ext_clk_i,
  input  logic                 ready_i,
  output logic [NUM_MODES-1:0] start_o,
  output logic [DATA_W-1:0]    data_o,
  output logic                 txe_o,
  output logic                 ovr_o
);
  logic [DATA_W-1:0] buf_q;
  logic              full_q, txe_q, ovr_q, armed_q;
  start_pol_e        pol;
  logic              go, wr;

  assign pol = pol_of(mode_i);
  assign wr  = we_i && !soft_rst_i;
  assign go  = full_q && ready_i &&
               ((pol == ST_ON_WRITE) ||
                (pol == ST_ON_EXT_CLK && ext_clk_i) ||
                (pol == ST_ON_TRIG && armed_q));

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_lane
    assign start_o[g] = go && (mode_i == MODE_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q   <= '0;
      full_q  <= 1'b0;
      txe_q   <= 1'b0;
      ovr_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (soft_rst_i) begin
      full_q  <= 1'b0;
      txe_q   <= 1'b0;
      ovr_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (wr) buf_q <= wdata_i;
      full_q  <= wr || (full_q && !go);
      // write clears empty flag and wins over a same-cycle hand-off
      txe_q   <= wr ? 1'b0 : (go ? 1'b1 : txe_q);
      ovr_q   <= ovr_q || (wr && full_q && !go);
      armed_q <= (pol == ST_ON_TRIG) && (trig_i || (armed_q && !go));
    end
  end

  assign data_o = buf_q;
  assign txe_o  = txe_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/sio_rx_buf.sv
module sio_rx_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              ovr_o
);
  logic [DATA_W-1:0] data_q;
  logic              full_q, ovr_q, ld;

  assign ld = done_i && !soft_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (soft_rst_i) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (ld) data_q <= rdata_i;
      full_q <= ld || (full_q && !re_i);
      ovr_q  <= ovr_q || (ld && full_q && !re_i);
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/sio_mode_ctrl.sv
module sio_mode_ctrl
  import sio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CFG_W  = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mode_we_i,
  input  logic [MODE_W-1:0]    mode_wdata_i,
  input  logic                 cfg_we_i,
  input  logic [CFG_W-1:0]     cfg_wdata_i,
  input  logic                 tx_we_i,
  input  logic [DATA_W-1:0]    tx_wdata_i,
  input  logic                 sw_trig_i,
  input  logic                 ext_clk_act_i,
  input  logic                 eng_ready_i,
  input  logic                 rx_done_i,
  input  logic [DATA_W-1:0]    rx_data_i,
  input  logic                 rd_re_i,
  output logic [MODE_W-1:0]    mode_o,
  output logic [CFG_W-1:0]     cfg_o,
  output logic                 soft_rst_o,
  output logic [NUM_MODES-1:0] start_o,
  output logic [DATA_W-1:0]    tx_data_o,
  output logic                 txe_o,
  output logic                 tx_ovr_o,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic                 rxf_o,
  output logic                 rx_ovr_o
);
  mode_e mode;
  logic  soft_rst;

  sio_mode_reg #(.CFG_W(CFG_W)) i_mode (
    .clk_i, .rst_ni, .mode_we_i, .mode_wdata_i, .cfg_we_i, .cfg_wdata_i,
    .mode_o(mode), .cfg_o, .soft_rst_o(soft_rst)
  );

  sio_tx_buf #(.DATA_W(DATA_W)) i_tx (
    .clk_i, .rst_ni, .mode_i(mode), .soft_rst_i(soft_rst),
    .we_i(tx_we_i), .wdata_i(tx_wdata_i), .trig_i(sw_trig_i),
    .ext_clk_i(ext_clk_act_i), .ready_i(eng_ready_i),
    .start_o, .data_o(tx_data_o), .txe_o, .ovr_o(tx_ovr_o)
  );

  sio_rx_buf #(.DATA_W(DATA_W)) i_rx (
    .clk_i, .rst_ni, .soft_rst_i(soft_rst), .done_i(rx_done_i),
    .rdata_i(rx_data_i), .re_i(rd_re_i),
    .data_o(rd_data_o), .full_o(rxf_o), .ovr_o(rx_ovr_o)
  );

  assign mode_o     = mode;
  assign soft_rst_o = soft_rst;
endmodule

// File: rtl/sio_mode_ctrl_chk.sv
module sio_mode_ctrl_chk
  import sio_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 mode_we_i,
  input logic [MODE_W-1:0]    mode_wdata_i,
  input logic                 tx_we_i,
  input logic                 rx_done_i,
  input logic                 ext_clk_act_i,
  input logic                 eng_ready_i,
  input logic [MODE_W-1:0]    mode_o,
  input logic                 soft_rst_o,
  input logic [NUM_MODES-1:0] start_o,
  input logic                 txe_o,
  input logic                 rxf_o
);
  logic to_reset;
  assign to_reset = mode_we_i && (mode_wdata_i == '0);

  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_o));

  p_lane_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|start_o) |-> start_o[mode_o]);

  p_mode_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != '0 && mode_we_i && mode_wdata_i != '0) |=> $stable(mode_o));

  p_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|start_o) |-> eng_ready_i);

  p_slave_clk_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o[MD_SPI_S] |-> ext_clk_act_i);

  p_txe_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|start_o) && !tx_we_i && !to_reset) |=> txe_o);

  p_rxf_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && !soft_rst_o && !to_reset) |=> rxf_o);

  p_quiet_start_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> (start_o == '0));

  p_quiet_flags_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> (!txe_o && !rxf_o));
endmodule

bind sio_mode_ctrl sio_mode_ctrl_chk i_chk (.*);

// File: tb/test_sio_mode_ctrl.sv
module test_sio_mode_ctrl;
  import sio_pkg::*;
  localparam int DW = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_we = 0, cfg_we = 0, tx_we = 0, trig = 0, ext_clk = 0, ready = 0;
  logic rx_done = 0, rd_re = 0;
  logic [2:0] mode_wd = '0;
  logic [CW-1:0] cfg_wd = '0;
  logic [DW-1:0] tx_wd = '0, rx_wd = '0;
  logic [2:0] mode_o;
  logic [CW-1:0] cfg_o;
  logic soft_rst_o, txe_o, tx_ovr_o, rxf_o, rx_ovr_o;
  logic [7:0] start_o;
  logic [DW-1:0] tx_data_o, rd_data_o;

  int checks = 0, errors = 0;
  logic [10:0] exp_q[$];

  always #4 clk = ~clk;

  sio_mode_ctrl #(.DATA_W(DW), .CFG_W(CW)) i_sio_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .mode_we_i(mode_we), .mode_wdata_i(mode_wd),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd), .tx_we_i(tx_we), .tx_wdata_i(tx_wd),
    .sw_trig_i(trig), .ext_clk_act_i(ext_clk), .eng_ready_i(ready),
    .rx_done_i(rx_done), .rx_data_i(rx_wd), .rd_re_i(rd_re),
    .mode_o, .cfg_o, .soft_rst_o, .start_o, .tx_data_o, .txe_o, .tx_ovr_o,
    .rd_data_o, .rxf_o, .rx_ovr_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(logic [2:0] m);
    mode_we = 1; mode_wd = m; tick(); mode_we = 0;
  endtask

  task automatic wr_cfg(logic [CW-1:0] v);
    cfg_we = 1; cfg_wd = v; tick(); cfg_we = 0;
  endtask

  task automatic wr_tx(logic [DW-1:0] v);
    tx_we = 1; tx_wd = v; tick(); tx_we = 0;
  endtask

  task automatic push(logic [2:0] m, logic [DW-1:0] v);
    exp_q.push_back({m, v});
  endtask

  // scoreboard monitor: samples late in the low phase, inputs stable since negedge
  always begin
    @(negedge clk); #3;
    if (rst_n && (|start_o)) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5 unexpected start actual %b/%h expected none", start_o, tx_data_o);
      end else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        if (start_o !== (8'b1 << e[10:8]) || tx_data_o !== e[7:0]) begin
          errors++;
          $display("FAIL R2 start actual %b/%h expected %b/%h",
                   start_o, tx_data_o, 8'b1 << e[10:8], e[7:0]);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(2); rst_n = 1; tick();
    // R1 reset state
    chk("R1 mode", mode_o, 0);
    chk("R1 soft_rst", soft_rst_o, 1);
    chk("R1 flags", {start_o, txe_o, tx_ovr_o, rxf_o, rx_ovr_o, cfg_o}, 0);

    // R4 config ignored in mode 0
    wr_cfg(8'h5A);
    chk("R4 cfg in mode0", cfg_o, 0);
    set_mode(3'd1);
    chk("R2 mode uart", mode_o, 1);
    chk("R2 soft_rst off", soft_rst_o, 0);
    wr_cfg(8'hA5);
    chk("R4 cfg accepted", cfg_o, 8'hA5);

    // R3 direct switch ignored
    set_mode(3'd2);
    chk("R3 mode held", mode_o, 1);

    // R5 immediate start
    ready = 1;
    push(3'd1, 8'h3C); wr_tx(8'h3C); tick();
    chk("R8 txe after start", txe_o, 1);

    // R8 collision of start and write
    ready = 0;
    wr_tx(8'h11); tick(2);
    chk("R5 no start while busy", txe_o, 0);
    push(3'd1, 8'h11); push(3'd1, 8'h22);
    ready = 1; tx_we = 1; tx_wd = 8'h22; tick(); tx_we = 0;
    chk("R8 txe low after collision", txe_o, 0);
    tick();
    chk("R8 txe after second start", txe_o, 1);
    chk("R9 no overrun on collision", tx_ovr_o, 0);

    // R9 overrun
    ready = 0;
    wr_tx(8'h55); wr_tx(8'h66);
    chk("R9 overrun set", tx_ovr_o, 1);
    chk("R9 txe low", txe_o, 0);
    push(3'd1, 8'h66); ready = 1; tick(2);
    chk("R9 replaced byte sent", txe_o, 1);

    // R6 SPI slave waits for external clock
    set_mode(3'd0); tick();
    chk("R12 overrun cleared", tx_ovr_o, 0);
    set_mode(3'd3);
    wr_tx(8'h81); tick(3);
    chk("R6 held without clock", txe_o, 0);
    push(3'd3, 8'h81); ext_clk = 1; tick(); ext_clk = 0;
    chk("R6 sent on clock", txe_o, 1);

    // R7 I2C master waits for trigger
    set_mode(3'd0); set_mode(3'd4);
    wr_tx(8'h42); tick(3);
    chk("R7 held without trigger", txe_o, 0);
    push(3'd4, 8'h42); trig = 1; tick(); trig = 0; tick();
    chk("R7 sent after trigger", txe_o, 1);
    trig = 1; tick(); trig = 0; tick(2);
    push(3'd4, 8'h43); wr_tx(8'h43); tick();
    chk("R7 armed trigger then write", txe_o, 1);

    // R2 lanes for other write-driven modes
    for (int i = 0; i < 3; i++) begin
      logic [2:0] m;
      m = (i == 0) ? 3'd2 : (i == 1) ? 3'd6 : 3'd7;
      set_mode(3'd0); set_mode(m);
      push(m, 8'hF0 + 8'(i)); wr_tx(8'hF0 + 8'(i)); tick();
      chk("R2 lane start", txe_o, 1);
    end

    // R10, R11 receive side in mode 7
    rx_done = 1; rx_wd = 8'h9A; tick(); rx_done = 0;
    chk("R10 rxf set", rxf_o, 1);
    chk("R10 data", rd_data_o, 8'h9A);
    rd_re = 1; tick(); rd_re = 0;
    chk("R10 rxf cleared", rxf_o, 0);
    chk("R10 data held", rd_data_o, 8'h9A);
    rx_done = 1; rx_wd = 8'h01; tick(); rx_wd = 8'h02; tick(); rx_done = 0;
    chk("R11 overrun", rx_ovr_o, 1);
    chk("R11 replaced", rd_data_o, 8'h02);

    // R12 soft reset clears and ignores
    set_mode(3'd0); tick();
    chk("R12 rx cleared", {rxf_o, rx_ovr_o, txe_o}, 0);
    rx_done = 1; rx_wd = 8'h33; tick(); rx_done = 0;
    chk("R12 rx ignored", rxf_o, 0);
    wr_tx(8'h77); set_mode(3'd1); tick(3);
    chk("R12 tx ignored", txe_o, 0);

    chk("R5 all starts seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule